// File: doc/BRIEF.md
# Trigger Symbol Stream Decoder

This block sits behind a link receiver that has already recovered the clock and turned pulse-width patterns into symbol codes. Each cycle may carry one symbol, a 4-bit code qualified by a valid strobe. Codes 0 to 7 each carry three data bits. Code 8 is a control symbol: it ends a transmission and also fills the line while nothing is being sent. The idle line alternates codes 7 and 8. For that reason a 7 is never taken as the first symbol of a frame.

A frame starts with a trigger identifier. In the downstream direction the identifier is two symbols wide, which gives 56 trigger numbers. In the upstream direction it is one symbol wide, which gives 7. The identifier is followed by a 64-bit payload sent as 22 three-bit symbols, most significant first. The block delivers each completed frame as a one-cycle pulse that comes with the trigger number and the payload. If a frame is cut short by a control symbol, the block drops it and raises a one-cycle error pulse.

The decoder recovers by itself. A control symbol sends it back to idle from any state, so a corrupted transmission cannot affect anything after the next control symbol.

Top module: `trig_sym_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `trig_valid` and `frame_err` are 0 and `trig_num` and `trig_payload` are all zeros.
- R2: Codes 0 to 7 are data symbols whose three data bits equal the code. Code 8 is the control symbol. Codes 9 to 15, and cycles with `sym_valid` low, have no effect on the frame in progress.
- R3: A code 7 received while the decoder is idle is ignored and does not start a frame.
- R4: With `UPLINK`=0 a frame opens with two identifier symbols a then b, where a is 0 to 6. The reported `trig_num` is a*8+b, always in the range 0 to 55.
- R5: With `UPLINK`=1 a frame opens with one identifier symbol a, 0 to 6, and the reported `trig_num` equals a.
- R6: The 22 payload symbols are joined most significant first into 66 bits, and `trig_payload` is the low 64 bits of that value. `trig_valid` is high for exactly the one cycle after the clock edge that takes the last payload symbol. `trig_num` and `trig_payload` keep their values until the next completed frame.
- R7: A control symbol returns the decoder to idle from any state. If it arrives after the first identifier symbol but before the last payload symbol, the frame is dropped without a `trig_valid` pulse, and `frame_err` is high for the one following cycle.
- R8: A control symbol received while idle, including the one that closes a completed frame, does not raise `frame_err`.
- R9: Symbols may arrive back to back or with gaps of any length between them, and a frame that follows a dropped one is decoded correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Qualifies `sym_code` in this cycle |
| sym_code | input | 4 | Received symbol code, 0 to 8 defined |
| trig_valid | output | 1 | One-cycle pulse for a completed frame |
| trig_num | output | 6 | Trigger number of the last completed frame |
| trig_payload | output | 64 | Payload of the last completed frame |
| frame_err | output | 1 | One-cycle pulse for a frame cut short |

## Verification
If the frame state is wrong, the ports show it at the end of the frame being received. A symbol-count error makes the `trig_valid` pulse come early or late, which the scoreboard detects as an unexpected or missing event. An error in the identifier or in the shift order shows up as a wrong number or payload in that same pulse. A decoder that fails to return to idle on a control symbol is exposed by the next frame: that frame is either mis-decoded or reported as an error. A code 7 or an out-of-range code that is wrongly consumed as data shifts every later field of the frame, so a wrong value is visible within one frame.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ID2  = 2'd1,
    ST_PAY  = 2'd2
  } tsd_state_e;

  localparam int CTRL_CODE = 8;
  localparam int FILL_CODE = 7;

  // number of data symbols needed to cover a payload word
  function automatic int tsd_pay_symbols(input int out_w, input int dbits);
    return (out_w + dbits - 1) / dbits;
  endfunction

  // trigger number from identifier symbols; single-symbol form uses hi only
  function automatic logic [5:0] tsd_trig_number(input logic [2:0] hi,
                                                 input logic [2:0] lo,
                                                 input logic two_sym);
    return two_sym ? {hi, lo} : {3'b000, hi};
  endfunction

endpackage

// File: rtl/tsd_sym_classify.sv
module tsd_sym_classify #(
  parameter int SYM_W = 4,
  parameter int DBITS = 3
) (
  input  logic             vld,
  input  logic [SYM_W-1:0] code,
  output logic             is_data,
  output logic             is_ctrl,
  output logic [DBITS-1:0] dbits
);
  localparam int NDATA = 1 << DBITS;

  always_comb begin
    is_data = vld && (int'(code) < NDATA);
    is_ctrl = vld && (int'(code) == tsd_pkg::CTRL_CODE);
    dbits   = code[DBITS-1:0];
  end
endmodule

// File: rtl/tsd_frame_fsm.sv
module tsd_frame_fsm #(
  parameter int DBITS    = 3,
  parameter bit TWO_ID   = 1'b1,
  parameter int PAY_SYMS = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_data,
  input  logic             is_ctrl,
  input  logic [DBITS-1:0] dbits,
  output logic             start,
  output logic             id_lo_ld,
  output logic             pay_shift,
  output logic             frame_done,
  output logic             frame_abort,
  output logic             in_idle
);
  import tsd_pkg::*;
  localparam int CNT_W = $clog2(PAY_SYMS);

  tsd_state_e       state, state_nx;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    in_idle     = (state == ST_IDLE);
    start       = in_idle && is_data && (int'(dbits) != FILL_CODE);
    id_lo_ld    = (state == ST_ID2) && is_data;
    pay_shift   = (state == ST_PAY) && is_data;
    frame_done  = pay_shift && (cnt == CNT_W'(PAY_SYMS - 1));
    frame_abort = is_ctrl && !in_idle;

    state_nx = state;
    if (is_ctrl)         state_nx = ST_IDLE;
    else if (start)      state_nx = TWO_ID ? ST_ID2 : ST_PAY;
    else if (id_lo_ld)   state_nx = ST_PAY;
    else if (frame_done) state_nx = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      if (state_nx != ST_PAY)  cnt <= '0;
      else if (pay_shift)      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tsd_shift_acc.sv
module tsd_shift_acc #(
  parameter int DBITS = 3,
  parameter int OUT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic [DBITS-1:0] din,
  output logic [OUT_W-1:0] word_nx
);
  logic [OUT_W-1:0] acc;

  // bits above OUT_W fall off the top, so no clear is needed per frame
  always_comb word_nx = {acc[OUT_W-DBITS-1:0], din};

  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (shift) acc <= word_nx;
  end
endmodule

// File: rtl/trig_sym_decoder.sv
module trig_sym_decoder #(
  parameter int SYM_W     = 4,
  parameter int DBITS     = 3,
  parameter int PAYLOAD_W = 64,
  parameter bit UPLINK    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sym_valid,
  input  logic [SYM_W-1:0]     sym_code,
  output logic                 trig_valid,
  output logic [2*DBITS-1:0]   trig_num,
  output logic [PAYLOAD_W-1:0] trig_payload,
  output logic                 frame_err
);
  import tsd_pkg::*;
  localparam int  PAY_SYMS = tsd_pay_symbols(PAYLOAD_W, DBITS);
  localparam bit  TWO_ID   = !UPLINK;
  localparam int  NUM_W    = 2 * DBITS;

  logic             sym_data, sym_ctrl;
  logic [DBITS-1:0] sym_bits;
  logic             ev_start, ev_id_lo, ev_shift, ev_done, ev_abort, fsm_idle;
  logic [PAYLOAD_W-1:0] pay_nx;
  logic [NUM_W-1:0]     id_num;

  tsd_sym_classify #(.SYM_W(SYM_W), .DBITS(DBITS)) u_cls (
    .vld(sym_valid), .code(sym_code),
    .is_data(sym_data), .is_ctrl(sym_ctrl), .dbits(sym_bits)
  );

  tsd_frame_fsm #(.DBITS(DBITS), .TWO_ID(TWO_ID), .PAY_SYMS(PAY_SYMS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .is_data(sym_data), .is_ctrl(sym_ctrl),
    .dbits(sym_bits), .start(ev_start), .id_lo_ld(ev_id_lo),
    .pay_shift(ev_shift), .frame_done(ev_done), .frame_abort(ev_abort),
    .in_idle(fsm_idle)
  );

  tsd_shift_acc #(.DBITS(DBITS), .OUT_W(PAYLOAD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .shift(ev_shift), .din(sym_bits), .word_nx(pay_nx)
  );

  generate
    if (TWO_ID) begin : g_two_id
      logic [DBITS-1:0] id_hi;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          id_hi  <= '0;
          id_num <= '0;
        end else begin
          if (ev_start) id_hi  <= sym_bits;
          if (ev_id_lo) id_num <= tsd_trig_number(id_hi, sym_bits, 1'b1);
        end
      end
    end else begin : g_one_id
      always_ff @(posedge clk) begin
        if (!rst_n)        id_num <= '0;
        else if (ev_start) id_num <= tsd_trig_number(sym_bits, 3'b000, 1'b0);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_valid   <= 1'b0;
      frame_err    <= 1'b0;
      trig_num     <= '0;
      trig_payload <= '0;
    end else begin
      trig_valid <= ev_done;
      frame_err  <= ev_abort;
      if (ev_done) begin
        trig_num     <= id_num;
        trig_payload <= pay_nx;
      end
    end
  end
endmodule

// File: rtl/tsd_checker.sv
module tsd_checker #(
  parameter int SYM_W     = 4,
  parameter int NUM_W     = 6,
  parameter int PAYLOAD_W = 64,
  parameter bit UPLINK    = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sym_valid,
  input logic [SYM_W-1:0]     sym_code,
  input logic                 trig_valid,
  input logic [NUM_W-1:0]     trig_num,
  input logic [PAYLOAD_W-1:0] trig_payload,
  input logic                 frame_err,
  input logic                 fsm_idle
);
  localparam int NUM_LIMIT = UPLINK ? 7 : 56;

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> !trig_valid);

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  assert_valid_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_valid && frame_err));

  assert_ctrl_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && int'(sym_code) == 8) |=> fsm_idle);

  assert_fill_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && sym_valid && int'(sym_code) == 7) |=> fsm_idle);

  assert_idle_ctrl_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_idle && sym_valid && int'(sym_code) == 8) |=> !frame_err);

  assert_num_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> (int'(trig_num) < NUM_LIMIT));

  assert_outputs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_valid |-> ($stable(trig_payload) && $stable(trig_num)));
endmodule

bind trig_sym_decoder tsd_checker #(
  .SYM_W(SYM_W), .NUM_W(2*DBITS), .PAYLOAD_W(PAYLOAD_W), .UPLINK(UPLINK)
) u_tsd_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
  .trig_valid(trig_valid), .trig_num(trig_num), .trig_payload(trig_payload),
  .frame_err(frame_err), .fsm_idle(fsm_idle)
);

// File: tb/tb_trig_sym_decoder.sv
module tb_trig_sym_decoder;
  typedef struct packed {
    logic        err;
    logic [5:0]  num;
    logic [63:0] pay;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dn_v = 1'b0, up_v = 1'b0;
  logic [3:0] dn_c = 4'd0, up_c = 4'd0;
  logic dn_tv, up_tv, dn_fe, up_fe;
  logic [5:0] dn_num, up_num;
  logic [63:0] dn_pay, up_pay;

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;
  exp_t q_dn[$];
  exp_t q_up[$];
  exp_t last_dn, last_up;

  always #4 clk = ~clk;

  trig_sym_decoder #(.UPLINK(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .sym_valid(dn_v), .sym_code(dn_c),
    .trig_valid(dn_tv), .trig_num(dn_num), .trig_payload(dn_pay), .frame_err(dn_fe)
  );

  trig_sym_decoder #(.UPLINK(1'b1)) dut_up (
    .clk(clk), .rst_n(rst_n), .sym_valid(up_v), .sym_code(up_c),
    .trig_valid(up_tv), .trig_num(up_num), .trig_payload(up_pay), .frame_err(up_fe)
  );

  task automatic check(input bit ok, input string req, input string msg);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // monitor: compares every output event against the scoreboard
  task automatic judge(input string side, input logic tv, input logic fe,
                       input logic [5:0] num, input logic [63:0] pay, inout exp_t q[$]);
    exp_t e;
    if (!(tv || fe)) return;
    if (q.size() == 0) begin
      check(1'b0, "R7", $sformatf("%s unexpected event valid=%0b err=%0b expected none", side, tv, fe));
      return;
    end
    e = q.pop_front();
    if (e.err)
      check(fe && !tv, "R7", $sformatf("%s abort: actual valid=%0b err=%0b expected valid=0 err=1", side, tv, fe));
    else
      check(tv && !fe && num == e.num && pay == e.pay, "R6",
            $sformatf("%s frame: actual v=%0b e=%0b num=%0d pay=%h expected v=1 e=0 num=%0d pay=%h",
                      side, tv, fe, num, pay, e.num, e.pay));
  endtask

  always @(negedge clk) if (rst_n) begin
    judge("down", dn_tv, dn_fe, dn_num, dn_pay, q_dn);
    judge("up",   up_tv, up_fe, up_num, up_pay, q_up);
  end

  task automatic send(input bit up, input logic [3:0] c);
    @(negedge clk);
    if (up) begin up_v = 1'b1; up_c = c; end
    else    begin dn_v = 1'b1; dn_c = c; end
  endtask

  task automatic quiet();
    @(negedge clk);
    dn_v = 1'b0; up_v = 1'b0;
  endtask

  task automatic send_frame(input bit up, input int a, input int b,
                            input logic [65:0] val, input bit junk);
    exp_t e;
    e.err = 1'b0;
    e.num = up ? 6'(a) : 6'(a * 8 + b);   // R4 / R5 numbering
    e.pay = val[63:0];
    if (up) begin q_up.push_back(e); last_up = e; end
    else    begin q_dn.push_back(e); last_dn = e; end
    send(up, 4'(a));
    if (!up) send(up, 4'(b));
    for (int i = 0; i < 22; i++) begin
      send(up, {1'b0, val[65 - 3*i -: 3]});
      if (junk && i == 5) begin   // R2 / R9: codes 9..15 and gaps mid-frame
        send(up, 4'd12);
        quiet();
        send(up, 4'd15);
        quiet();
        quiet();
      end
    end
    send(up, 4'd8);
    quiet();
  endtask

  task automatic send_abort(input bit up, input int nid, input int npay);
    exp_t e;
    e = '0;
    e.err = 1'b1;
    if (up) q_up.push_back(e); else q_dn.push_back(e);
    for (int i = 0; i < nid; i++) send(up, 4'(3 + i));
    for (int i = 0; i < npay; i++) send(up, 4'(i % 8));
    send(up, 4'd8);
    quiet();
  endtask

  task automatic check_hold();
    quiet(); quiet();
    check(dn_num == last_dn.num && dn_pay == last_dn.pay && !dn_tv, "R6",
          $sformatf("down hold: actual num=%0d pay=%h expected num=%0d pay=%h",
                    dn_num, dn_pay, last_dn.num, last_dn.pay));
    check(up_num == last_up.num && up_pay == last_up.pay && !up_tv, "R6",
          $sformatf("up hold: actual num=%0d pay=%h expected num=%0d pay=%h",
                    up_num, up_pay, last_up.num, last_up.pay));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "R9", "watchdog expired: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    last_dn = '0; last_up = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!dn_tv && !dn_fe && dn_num == 0 && dn_pay == 0 && !up_tv && !up_fe &&
          up_num == 0 && up_pay == 0, "R1",
          $sformatf("reset: actual dn v=%0b e=%0b num=%0d up v=%0b e=%0b expected all 0",
                    dn_tv, dn_fe, dn_num, up_tv, up_fe));
    rst_n = 1'b1;
    @(negedge clk);
    check(!dn_tv && !dn_fe && dn_pay == 0 && !up_tv && !up_fe && up_pay == 0, "R1",
          "after reset release: actual nonzero expected all 0");

    // R3 / R8: idle fill pattern, no events expected
    for (int i = 0; i < 4; i++) begin send(0, 4'd7); send(0, 4'd8); end
    send(0, 4'd8);
    quiet();
    check(!dn_fe && !dn_tv, "R8", $sformatf("idle ctrl: actual err=%0b valid=%0b expected 0 0", dn_fe, dn_tv));

    // R4 / R6: downlink frames
    send_frame(0, 0, 0, 66'h0, 0);
    check_hold();
    send_frame(0, 6, 7, {66{1'b1}}, 0);
    send_frame(0, 3, 5, 66'h2_F0E1_D2C3_B4A5_9687, 0);
    check_hold();
    // R3: fill symbol in idle, then a frame; a consumed 7 would change the number
    send(0, 4'd7);
    send_frame(0, 2, 1, 66'h1_0123_4567_89AB_CDEF, 1);
    // R7: aborts at several depths, then R9 recovery
    send_abort(0, 1, 0);
    send_abort(0, 2, 0);
    send_abort(0, 2, 21);
    send_frame(0, 5, 4, 66'h3_5555_AAAA_0F0F_F0F0, 0);
    send(0, 4'd8); quiet();
    check(!dn_fe, "R8", "ctrl after frame end: actual err=1 expected 0");

    // R5: uplink frames
    send(1, 4'd7);
    send_frame(1, 4, 0, 66'h0_DEAD_BEEF_CAFE_F00D, 0);
    send_frame(1, 6, 0, 66'h3_8000_0000_0000_0001, 1);
    send_abort(1, 1, 0);
    send_abort(1, 1, 10);
    send_frame(1, 0, 0, 66'h1_1234_5678_9ABC_DEF0, 0);
    check_hold();

    repeat (4) @(negedge clk);
    check(q_dn.size() == 0 && q_up.size() == 0, "R6",
          $sformatf("pending events: actual dn=%0d up=%0d expected 0 0", q_dn.size(), q_up.size()));
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule